// File: doc/BRIEF.md
# Source/Sink Pattern Sequencer

The block stores a per-clock pattern of eight timing signals and plays it back on a source port, one memory word per clock, while a second engine can record eight incoming signals into the other half of the same memory. Each memory word is 16 bits wide. The low byte is the source pattern and the high byte is the recorded sink data. Software reaches the memory and two control registers through a simple 16-bit register bus. Decoding of that bus from a system protocol happens outside the block.

Both engines start at address 0 and step the address by one each clock until they reach the programmed end address. At that point they either wrap back to 0 (cyclic mode) or stop. A go strobe starts an engine only on a 0-to-1 write of its control bit. A level reset bit holds an engine idle. Per-signal enables gate every source output.

Top module: `pattern_sequencer`

## Requirements
- R1: A bus write with address bit ADDR_W set stores a word in the memory at address `bus_addr_i[ADDR_W-1:0]`: the source byte in bits 7:0 and the sink byte in bits 15:8. A read of the same address returns the stored word combinationally on `bus_rdata_o`.
- R2: A 0-to-1 write of control bit 9 (source go) starts the source one clock after the write edge. The source then shows the words at addresses 0,1,2,... on consecutive clocks, and `src_busy_o` is high for that whole time.
- R3: While the source runs, `source_o[i]` is 1 only when bit i of the stored source byte and control bit i (enable i, for bits 7:0) are both 1. While the source is idle, `source_o` is 0. The bit order is: trigger, event-counter reset, bunch-counter reset, calibrate, serial ID, serial trigger type, front-end reset, spare.
- R4: With control bit 10 (cyclic) clear, a run lasts exactly end+1 clocks, and the engine then goes idle. End value 0 gives a one-clock run.
- R5: With cyclic set, address 0 follows the end address and the run continues without a break.
- R6: Writing 1 to a go bit that already holds 1 starts nothing. The bit must first be written to 0.
- R7: A go edge that arrives while the engine is running is ignored, and the run keeps its original length.
- R8: Control bit 8 (source reset) makes the source idle on the clock after it is written. A go edge given while the reset is held is lost, and releasing the reset starts nothing.
- R9: A 0-to-1 write of control bit 12 (sink go) starts the sink and the source on the same clock. While the sink runs at address k, the value on `sink_i` is written into the sink byte of word k, and the source byte is left unchanged.
- R10: Control bit 11 (sink reset) stops only the sink, one clock after it is written. A running source keeps going.
- R11: Register address 0 is the control register, whose bits 12:0 read back as written and whose bits 15:13 read 0. Register address 1 is the end-address register: 14 bits, with bits 15:14 reading 0. Both registers reset to 0, and both engines reset to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | ADDR_W+1 | Bit ADDR_W high selects memory, otherwise register index |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the addressed location |
| sink_i | input | 8 | Signals recorded by the sink |
| source_o | output | 8 | Gated pattern played by the source |
| src_busy_o | output | 1 | Source running |
| snk_busy_o | output | 1 | Sink running |

## Verification
The whole memory is filled with a word computed from its address and read back. This separates the two byte lanes and catches any address aliasing. Source runs are repeated with the enable masks all-ones, 0xA5, 0x5A and all-zeros, so that gating errors show up per bit. End values of 0, 7 and the top address are used, and a cyclic pass over four words shows the wrap. Repeated go writes, go edges during a run, go edges under reset and a mid-run reset each have their own signature in the busy count. A sink run with a stimulus that changes every clock is read back word by word, which shows that recording lands at the right address and that neighbouring bytes stay intact.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
  localparam int SIG_W       = 8;
  localparam int CTL_RST_SRC = 8;
  localparam int CTL_GO_SRC  = 9;
  localparam int CTL_CYCLIC  = 10;
  localparam int CTL_RST_SNK = 11;
  localparam int CTL_GO_SNK  = 12;
  localparam int CTL_W       = 13;
  localparam int END_W       = 14;
  localparam int BUS_W       = 16;
endpackage

// File: rtl/pseq_regs.sv
module pseq_regs
  import pseq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_ctrl_i,
  input  logic               we_end_i,
  input  logic [BUS_W-1:0]   wdata_i,
  output logic [CTL_W-1:0]   ctrl_o,
  output logic [END_W-1:0]   end_o,
  output logic               go_src_o,
  output logic               go_snk_o
);
  logic [CTL_W-1:0] ctrl_q;
  logic [END_W-1:0] end_q;
  logic             go_src_q, go_snk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      end_q    <= '0;
      go_src_q <= 1'b0;
      go_snk_q <= 1'b0;
    end else begin
      // go fires only on a 0->1 transition of the stored bit
      go_src_q <= we_ctrl_i & wdata_i[CTL_GO_SRC] & ~ctrl_q[CTL_GO_SRC];
      go_snk_q <= we_ctrl_i & wdata_i[CTL_GO_SNK] & ~ctrl_q[CTL_GO_SNK];
      if (we_ctrl_i) ctrl_q <= wdata_i[CTL_W-1:0];
      if (we_end_i)  end_q  <= wdata_i[END_W-1:0];
    end
  end

  assign ctrl_o   = ctrl_q;
  assign end_o    = end_q;
  assign go_src_o = go_src_q;
  assign go_snk_o = go_snk_q;

  a_r6_go_needs_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[CTL_GO_SRC] |=> !go_src_q);
endmodule

// File: rtl/pseq_engine.sv
module pseq_engine #(
  parameter int AW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          go_i,
  input  logic          cyclic_i,
  input  logic [AW-1:0] end_i,
  output logic [AW-1:0] addr_o,
  output logic          run_o
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] addr_q;
  logic          run_q;
  logic          at_end;

  assign at_end = (addr_q >= end_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      run_q  <= 1'b0;
    end else if (clr_i) begin
      addr_q <= '0;
      run_q  <= 1'b0;
    end else if (!run_q) begin
      if (go_i) begin
        run_q  <= 1'b1;
        addr_q <= '0;
      end
    end else if (at_end) begin
      addr_q <= '0;
      run_q  <= cyclic_i;
    end else begin
      addr_q <= addr_q + ONE;
    end
  end

  assign addr_o = addr_q;
  assign run_o  = run_q;

  a_r8_clear_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!run_q && addr_q == '0));
  a_r4_stop_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !clr_i && at_end && !cyclic_i) |=> !run_q);
  a_r5_wrap_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !clr_i && at_end && cyclic_i) |=> (run_q && addr_q == '0));
  a_r7_step_ignores_go: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !clr_i && !at_end) |=> (run_q && addr_q == $past(addr_q) + ONE));
  a_r2_go_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && go_i && !clr_i) |=> (run_q && addr_q == '0));
endmodule

// File: rtl/pseq_mem.sv
module pseq_mem
  import pseq_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  input  logic [ADDR_W-1:0] src_addr_i,
  output logic [SIG_W-1:0]  src_byte_o,
  input  logic              snk_we_i,
  input  logic [ADDR_W-1:0] snk_addr_i,
  input  logic [SIG_W-1:0]  snk_byte_i
);
  localparam int DEPTH = 1 << ADDR_W;

  // no reset: contents undefined until written
  logic [SIG_W-1:0] src_mem [DEPTH];
  logic [SIG_W-1:0] snk_mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (bus_we_i) begin
      src_mem[bus_addr_i] <= bus_wdata_i[SIG_W-1:0];
      snk_mem[bus_addr_i] <= bus_wdata_i[BUS_W-1:SIG_W];
    end
    if (snk_we_i) snk_mem[snk_addr_i] <= snk_byte_i;  // recording wins a collision
  end

  assign bus_rdata_o = {snk_mem[bus_addr_i], src_mem[bus_addr_i]};
  assign src_byte_o  = src_mem[src_addr_i];
endmodule

// File: rtl/pattern_sequencer.sv
module pattern_sequencer
  import pseq_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W:0]   bus_addr_i,
  input  logic              bus_we_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  input  logic [SIG_W-1:0]  sink_i,
  output logic [SIG_W-1:0]  source_o,
  output logic              src_busy_o,
  output logic              snk_busy_o
);
  logic              mem_sel, ctrl_sel, end_sel;
  logic [CTL_W-1:0]  ctrl;
  logic [END_W-1:0]  end_addr;
  logic              go_src_p, go_snk_p;
  logic [END_W-1:0]  src_addr, snk_addr;
  logic              src_run, snk_run;
  logic [SIG_W-1:0]  src_byte;
  logic [BUS_W-1:0]  mem_rdata;

  assign mem_sel  = bus_addr_i[ADDR_W];
  assign ctrl_sel = !mem_sel && (bus_addr_i[ADDR_W-1:0] == ADDR_W'(0));
  assign end_sel  = !mem_sel && (bus_addr_i[ADDR_W-1:0] == ADDR_W'(1));

  pseq_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_ctrl_i (bus_we_i && ctrl_sel),
    .we_end_i  (bus_we_i && end_sel),
    .wdata_i   (bus_wdata_i),
    .ctrl_o    (ctrl),
    .end_o     (end_addr),
    .go_src_o  (go_src_p),
    .go_snk_o  (go_snk_p)
  );

  pseq_engine #(.AW(END_W)) u_src (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (ctrl[CTL_RST_SRC]),
    .go_i     (go_src_p | go_snk_p),  // sink go also starts the source
    .cyclic_i (ctrl[CTL_CYCLIC]),
    .end_i    (end_addr),
    .addr_o   (src_addr),
    .run_o    (src_run)
  );

  pseq_engine #(.AW(END_W)) u_snk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (ctrl[CTL_RST_SNK]),
    .go_i     (go_snk_p),
    .cyclic_i (ctrl[CTL_CYCLIC]),
    .end_i    (end_addr),
    .addr_o   (snk_addr),
    .run_o    (snk_run)
  );

  pseq_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk_i       (clk_i),
    .bus_we_i    (bus_we_i && mem_sel),
    .bus_addr_i  (bus_addr_i[ADDR_W-1:0]),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (mem_rdata),
    .src_addr_i  (src_addr[ADDR_W-1:0]),
    .src_byte_o  (src_byte),
    .snk_we_i    (snk_run),
    .snk_addr_i  (snk_addr[ADDR_W-1:0]),
    .snk_byte_i  (sink_i)
  );

  always_comb begin
    if (mem_sel)       bus_rdata_o = mem_rdata;
    else if (ctrl_sel) bus_rdata_o = BUS_W'(ctrl);
    else if (end_sel)  bus_rdata_o = BUS_W'(end_addr);
    else               bus_rdata_o = '0;
  end

  assign source_o   = src_run ? (src_byte & ctrl[SIG_W-1:0]) : '0;
  assign src_busy_o = src_run;
  assign snk_busy_o = snk_run;

  a_r3_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !src_busy_o |-> (source_o == '0));
  a_r9_sink_go_starts_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_snk_p && !ctrl[CTL_RST_SRC]) |=> src_busy_o);
endmodule

// File: tb/pattern_sequencer_tb.sv
module pattern_sequencer_tb_top;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 6;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int GO_S = 16'h0200, CYC = 16'h0400, RST_S = 16'h0100;
  localparam int RST_K = 16'h0800, GO_K = 16'h1000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W:0]   bus_addr = '0;
  logic              bus_we = 1'b0;
  logic [15:0]       bus_wdata = '0;
  logic [15:0]       bus_rdata;
  logic [7:0]        sink_v = '0;
  logic [7:0]        source_v;
  logic              src_busy, snk_busy;

  int n_chk = 0, n_fail = 0, busy_cnt = 0;
  logic [7:0] exp_snk [DEPTH];

  always #(CLK_P/2) clk = ~clk;
  always @(negedge clk) if (src_busy) busy_cnt++;

  pattern_sequencer #(.ADDR_W(ADDR_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(bus_addr), .bus_we_i(bus_we),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .sink_i(sink_v),
    .source_o(source_v), .src_busy_o(src_busy), .snk_busy_o(snk_busy)
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 5) & 255);
  endfunction
  function automatic logic [7:0] rec(int k);
    return 8'(((k * 91) ^ 8'h6C) & 255);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input int a, input int d);
    @(negedge clk);
    bus_addr = (ADDR_W+1)'(a); bus_wdata = 16'(d); bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(input int a, output int d);
    @(negedge clk);
    bus_addr = (ADDR_W+1)'(a);
    #1 d = int'(bus_rdata);
  endtask

  // plays one non-cyclic pass with enable mask en and end value e
  task automatic src_pass(input int en, input int e);
    bus_wr(1, e);
    bus_wr(0, en);
    bus_wr(0, en | GO_S);
    for (int k = 0; k <= e; k++) begin
      @(negedge clk);
      check("R2 busy during run", int'(src_busy), 1);
      check("R3 gated source", int'(source_v), int'(pat(k) & 8'(en)));
    end
    @(negedge clk);
    check("R4 idle after end+1", int'(src_busy), 0);
    check("R3 idle output zero", int'(source_v), 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state and register layout
    check("R11 reset src busy", int'(src_busy), 0);
    check("R11 reset snk busy", int'(snk_busy), 0);
    check("R3 reset source", int'(source_v), 0);
    bus_rd(0, d); check("R11 ctrl reset", d, 0);
    bus_rd(1, d); check("R11 end reset", d, 0);
    bus_wr(1, 16'hFFFF); bus_rd(1, d); check("R11 end 14 bits", d, 16'h3FFF);
    bus_wr(0, 16'hE4FF); bus_rd(0, d); check("R11 ctrl readback", d, 16'h04FF);
    bus_wr(0, 0);
    check("R11 no start from non-go bits", int'(src_busy), 0);

    // R1 fill and read back whole memory
    for (int a = 0; a < DEPTH; a++) begin
      exp_snk[a] = 8'(a ^ 8'h3C);
      bus_wr(DEPTH + a, {exp_snk[a], pat(a)});
    end
    for (int a = 0; a < DEPTH; a++) begin
      bus_rd(DEPTH + a, d);
      check("R1 word readback", d, int'({exp_snk[a], pat(a)}));
    end

    // R2 R3 R4 enable sweep and end boundaries
    src_pass(8'hFF, 7);
    src_pass(8'hA5, 7);
    src_pass(8'h5A, 7);
    src_pass(8'h00, 7);
    src_pass(8'hFF, 0);
    src_pass(8'h3C, DEPTH - 1);

    // R6 go bit already 1: no restart
    bus_wr(0, 8'hFF | GO_S);
    repeat (5) begin
      @(negedge clk);
      check("R6 repeated 1 ignored", int'(src_busy), 0);
    end

    // R7 go edge while running is ignored
    bus_wr(1, 20);
    bus_wr(0, 8'hFF);
    busy_cnt = 0;
    bus_wr(0, 8'hFF | GO_S);
    repeat (3) @(negedge clk);
    bus_wr(0, 8'hFF);
    bus_wr(0, 8'hFF | GO_S);
    do @(negedge clk); while (src_busy);
    #1 check("R7 run length unchanged", busy_cnt, 21);

    // R5 cyclic wrap
    bus_wr(1, 3);
    bus_wr(0, 8'hFF | CYC);
    bus_wr(0, 8'hFF | CYC | GO_S);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      check("R5 cyclic busy", int'(src_busy), 1);
      check("R5 cyclic wrap data", int'(source_v), int'(pat(k % 4)));
    end

    // R8 level reset
    bus_wr(0, 8'hFF | CYC | GO_S | RST_S);
    @(negedge clk);
    check("R8 reset stops source", int'(src_busy), 0);
    bus_wr(0, 8'hFF | RST_S);
    bus_wr(0, 8'hFF | RST_S | GO_S);
    repeat (4) begin
      @(negedge clk);
      check("R8 go under reset lost", int'(src_busy), 0);
    end
    bus_wr(0, 8'hFF | GO_S);
    repeat (3) begin
      @(negedge clk);
      check("R8 release starts nothing", int'(src_busy), 0);
    end
    bus_wr(0, 8'hFF);

    // R9 sink go starts both and records
    bus_wr(1, 9);
    bus_wr(0, 8'hFF | GO_K);
    for (int k = 0; k <= 9; k++) begin
      @(negedge clk);
      check("R9 sink busy", int'(snk_busy), 1);
      check("R9 source started too", int'(src_busy), 1);
      check("R9 source data", int'(source_v), int'(pat(k)));
      sink_v = rec(k);
      exp_snk[k] = rec(k);
    end
    @(negedge clk);
    check("R9 sink idle after end", int'(snk_busy), 0);
    check("R9 source idle after end", int'(src_busy), 0);
    for (int a = 0; a <= 10; a++) begin
      bus_rd(DEPTH + a, d);
      check("R9 recorded word", d, int'({exp_snk[a], pat(a)}));
    end

    // R10 sink reset leaves source running
    bus_wr(1, 30);
    bus_wr(0, 8'hFF);
    bus_wr(0, 8'hFF | GO_K);
    repeat (3) @(negedge clk);
    bus_wr(0, 8'hFF | GO_K | RST_K);
    @(negedge clk);
    check("R10 sink stopped", int'(snk_busy), 0);
    check("R10 source still runs", int'(src_busy), 1);
    bus_wr(0, 8'hFF | RST_S | RST_K);
    @(negedge clk);
    check("R8 source cleared", int'(src_busy), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule